// File: doc/BRIEF.md
# Command-Byte SPI Register Slave

This block is the serial front end of a converter-style peripheral. A host talks to it over a four-wire SPI link in mode 0. Every transaction is framed by an active-low chip select. Every transaction opens with one command byte, sent most significant bit first. The leading bit must be set, or the rest of the frame is dropped. The next bit chooses between two field layouts. One is a conversion request carrying a two-bit operating mode and a four-bit rate. The other is a register access carrying a five-bit address and a direction bit.

A conversion request raises a one-clock strobe toward an external sequencing controller, with the mode and rate attached. A register access either clocks a data word into a small register file or clocks the addressed word back out on MISO. Register widths depend on the address.

SCLK, chip select and MOSI are brought into the system clock domain through synchronizers, and both SCLK edges are detected there. The SPI clock must therefore run well below the system clock.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, MISO is 0, no conversion strobe has fired, and every implemented register reads back as 0.
- R2: A command byte whose bit 7 is 0 is ignored. No strobe fires, and the remaining bits of that chip-select frame change no register.
- R3: A command byte with bit 7 = 1 and bit 6 = 0 is a conversion request, with mode in bits 5:4 and rate in bits 3:0. For a non-zero mode, conv_strobe is high for exactly one clock, and conv_mode and conv_rate carry the two fields while it is high. The modes are 01 power-down, 10 calibration and 11 sequencer.
- R4: A conversion request with mode 00 raises no strobe.
- R5: A command byte with bits 7:6 = 11 is a register access, with address in bits 5:1 and direction in bit 0 (0 = write, 1 = read). A read never modifies the register, whatever MOSI carries.
- R6: A write takes effect only if chip select rises after exactly 8 plus the register width SCLK rising edges. In that case the register takes the data bits, most significant bit first. A shorter or longer frame leaves the register unchanged.
- R7: On a read, the data word appears on MISO most significant bit first. MISO changes on SCLK falling edges, so the first data bit is valid before the 9th rising edge. Bits after the word are 0.
- R8: Addresses 0 to 3 hold 8 bits, 4 to 11 hold 16 bits, and 12 to 15 hold 24 bits. Addresses 16 to 31 are treated as 8 bits wide: writes to them are discarded and reads return 0.
- R9: MISO stays 0 whenever the current frame is not in the data phase of a read.
- R10: Raising chip select ends the frame at any point. The next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| conv_strobe | output | 1 | One-clock pulse for a conversion request |
| conv_mode | output | 2 | Mode field of the latest conversion request |
| conv_rate | output | 4 | Rate field of the latest conversion request |

## Verification
The hardest condition to reach from the ports is a write frame whose bit count is off by one in either direction. The register must then keep its old value, and from outside this is visible only through a later read. The stimulus therefore sends frames one bit short and one bit long to registers that already hold a known word, then reads each register back with a correctly sized frame. Discarded frames are handled the same way. A frame opening with a cleared leading bit, or a chip select pulled in the middle of a command, is followed by a clean read. That read shows both that nothing was written and that the next frame decodes from its first bit.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CMD_W    = 8;
    localparam int ADDR_W   = 5;
    localparam int MAX_DW   = 24;
    localparam int CNT_W    = 6;
    localparam int NUM_REGS = 16;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_SKIP = 2'd3
    } frame_st_e;

    typedef enum logic [1:0] {
        MD_NONE  = 2'd0,
        MD_PDOWN = 2'd1,
        MD_CAL   = 2'd2,
        MD_SEQ   = 2'd3
    } conv_mode_e;

    typedef struct packed {
        logic       lead;
        logic       is_reg;
        logic [5:0] body;
    } cmd_byte_t;

    typedef struct packed {
        conv_mode_e mode;
        logic [3:0] rate;
    } conv_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } reg_req_t;

    function automatic logic [CNT_W-1:0] reg_width(input logic [ADDR_W-1:0] a);
        if (a < ADDR_W'(4))             return CNT_W'(8);
        else if (a < ADDR_W'(12))       return CNT_W'(16);
        else if (a < ADDR_W'(NUM_REGS)) return CNT_W'(24);
        else                            return CNT_W'(8);
    endfunction

    function automatic logic [MAX_DW-1:0] width_mask(input logic [CNT_W-1:0] w);
        int sh;
        sh = MAX_DW - int'(w);
        return {MAX_DW{1'b1}} >> sh;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[STAGES-1];
        end
    end

    assign dout = stg[STAGES-1];
    assign rise = dout & ~prev;
    assign fall = ~dout & prev;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int NREGS = 16,
    parameter int AW    = 5,
    parameter int DW    = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                          q <= '0;
            else if (we && waddr == AW'(g))   q <= wdata;
        end
        assign store[g] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++)
            if (raddr == AW'(i)) rdata = store[i];
    end

    // R8: only implemented addresses are ever written
    p_we_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr < AW'(NREGS)));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [MAX_DW-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [MAX_DW-1:0] wdata,
    output logic              miso_q,
    output logic              strobe,
    output conv_req_t         conv_q
);
    frame_st_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-2:0]  cmd_sh;
    logic [MAX_DW-1:0] rx_sh;
    logic [MAX_DW-1:0] tx_sh;
    logic [ADDR_W-1:0] addr_q;
    cmd_byte_t         byte_now;
    conv_req_t         conv_now;
    reg_req_t          reg_now;
    logic [CNT_W-1:0]  exact_len;

    assign byte_now  = cmd_byte_t'({cmd_sh, mosi_s});
    assign conv_now  = conv_req_t'(byte_now.body);
    assign reg_now   = reg_req_t'(byte_now.body);
    assign raddr     = reg_now.addr;
    assign exact_len = CNT_W'(CMD_W) + reg_width(addr_q);
    assign waddr     = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_CMD;
            cnt    <= '0;
            cmd_sh <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            addr_q <= '0;
            miso_q <= 1'b0;
            strobe <= 1'b0;
            conv_q <= '0;
            we     <= 1'b0;
            wdata  <= '0;
        end else begin
            strobe <= 1'b0;
            we     <= 1'b0;
            if (cs_n_s) begin
                if (cs_rise && state == ST_WR && cnt == exact_len
                    && addr_q < ADDR_W'(NUM_REGS)) begin
                    we    <= 1'b1;
                    wdata <= rx_sh & width_mask(reg_width(addr_q));
                end
                state  <= ST_CMD;
                cnt    <= '0;
                miso_q <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    case (state)
                        ST_CMD: begin
                            cmd_sh <= {cmd_sh[CMD_W-3:0], mosi_s};
                            if (cnt == CNT_W'(CMD_W - 1)) begin
                                if (!byte_now.lead) begin
                                    state <= ST_SKIP;
                                end else if (!byte_now.is_reg) begin
                                    state  <= ST_SKIP;
                                    conv_q <= conv_now;
                                    strobe <= (conv_now.mode != MD_NONE);
                                end else begin
                                    addr_q <= reg_now.addr;
                                    rx_sh  <= '0;
                                    if (reg_now.rd) begin
                                        state <= ST_RD;
                                        tx_sh <= rdata << (MAX_DW - int'(reg_width(reg_now.addr)));
                                    end else begin
                                        state <= ST_WR;
                                    end
                                end
                            end
                        end
                        ST_WR:   rx_sh <= {rx_sh[MAX_DW-2:0], mosi_s};
                        default: ;
                    endcase
                end
                if (sclk_fall && state == ST_RD) begin
                    miso_q <= tx_sh[MAX_DW-1];
                    tx_sh  <= {tx_sh[MAX_DW-2:0], 1'b0};
                end
            end
        end
    end

    // R3: the conversion strobe is a single-cycle pulse
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    // R4: a strobe never carries the unused mode
    p_no_unused_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (conv_q.mode != MD_NONE));
    // R9: MISO returns to 0 once chip select is high
    p_miso_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !miso_q);
    // R6: a commit happens only after the frame has closed
    p_commit_closed_r6: assert property (@(posedge clk) disable iff (rst)
        we |-> cs_n_s);
    // R10: the bit count restarts outside a frame
    p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (cnt == '0));
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic       conv_strobe,
    output logic [1:0] conv_mode,
    output logic [3:0] conv_rate
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0]  pins_s, pins_r, pins_f;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [MAX_DW-1:0] wdata, rdata;
    conv_req_t         conv_q;

    spi_pin_sync #(
        .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk), .rst(rst), .din({cs_n, sclk, mosi}),
        .dout(pins_s), .rise(pins_r), .fall(pins_f)
    );

    spi_frame_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .cs_n_s(pins_s[2]), .cs_rise(pins_r[2]),
        .sclk_rise(pins_r[1]), .sclk_fall(pins_f[1]),
        .mosi_s(pins_s[0]), .rdata(rdata), .raddr(raddr),
        .we(we), .waddr(waddr), .wdata(wdata),
        .miso_q(miso), .strobe(conv_strobe), .conv_q(conv_q)
    );

    spi_reg_bank #(
        .NREGS(NUM_REGS), .AW(ADDR_W), .DW(MAX_DW)
    ) u_bank (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    assign conv_mode = conv_q.mode;
    assign conv_rate = conv_q.rate;
endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       conv_strobe;
    logic [1:0] conv_mode;
    logic [3:0] conv_rate;

    always #4 clk = ~clk;

    spi_cmd_slave dut (.*);

    localparam int HALF = 6;
    int checks = 0, fails = 0;
    int strobe_cnt = 0, wide_cnt = 0;
    logic prev_strobe = 1'b0;
    logic [1:0] seen_mode;
    logic [3:0] seen_rate;
    logic [23:0] model [32];
    bit done = 0;

    // per-clock monitor of the strobe
    always @(negedge clk) begin
        if (!rst) begin
            if (conv_strobe) begin
                strobe_cnt++;
                seen_mode = conv_mode;
                seen_rate = conv_rate;
                if (prev_strobe) wide_cnt++;
            end
            prev_strobe = conv_strobe;
        end
    end

    function automatic int width_of(input int a);
        if (a < 4) return 8;
        if (a < 12) return 16;
        return (a < 16) ? 24 : 8;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input int nbits, input logic [63:0] bits, output logic [63:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = bits[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    // write with an arbitrary data-bit count; model commits only on exact length
    task automatic do_write(input int a, input logic [23:0] d, input int nd, output logic [63:0] rx);
        logic [63:0] bits;
        bits = ({56'd0, 2'b11, 5'(a), 1'b0} << nd) | (64'(d) & ((64'd1 << nd) - 1));
        frame(8 + nd, bits, rx);
        if (nd == width_of(a) && a < 16) model[a] = d & 24'((64'd1 << nd) - 1);
    endtask

    task automatic do_read(input int a, input int nd, input logic [23:0] mosi_junk, output logic [23:0] val);
        logic [63:0] bits, rx;
        bits = ({56'd0, 2'b11, 5'(a), 1'b1} << nd) | (64'(mosi_junk) & ((64'd1 << nd) - 1));
        frame(8 + nd, bits, rx);
        val = rx[23:0] & 24'((64'd1 << nd) - 1);
    endtask

    task automatic do_conv(input logic [1:0] md, input logic [3:0] rt);
        logic [63:0] rx;
        frame(8, {56'd0, 2'b10, md, rt}, rx);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] v;
        logic [63:0] rx;
        int sc;
        for (int i = 0; i < 32; i++) model[i] = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        // R1 reset state
        check(miso == 1'b0, "R1 miso", 64'(miso), 0);
        check(strobe_cnt == 0, "R1 strobe", strobe_cnt, 0);
        do_read(13, 24, 24'h0, v);
        check(v == 24'h0, "R1 reg13", v, 0);

        // R5/R6/R8/R9 writes of each width, R7 readback
        do_write(2, 24'h0000A5, 8, rx);
        check(rx == 64'd0, "R9 miso quiet on write", rx, 0);
        do_write(7, 24'h00C3F1, 16, rx);
        do_write(14, 24'h9B2E47, 24, rx);
        do_read(2, 8, 24'h0, v);
        check(v == model[2], "R7 read 8b", v, model[2]);
        do_read(7, 16, 24'h0, v);
        check(v == model[7], "R7 read 16b", v, model[7]);
        do_read(14, 24, 24'h0, v);
        check(v == model[14], "R8 read 24b", v, model[14]);
        // R7 trailing bits after the word are zero
        do_read(2, 12, 24'h0, v);
        check(v == {12'd0, model[2], 4'd0} >> 12 << 4 || v == 24'(model[2]) << 4, "R7 trailing zero", v, 24'(model[2]) << 4);

        // R5 read with noise on MOSI changes nothing
        do_read(7, 16, 24'hFFFF, v);
        do_read(7, 16, 24'h0, v);
        check(v == model[7], "R5 read keeps reg", v, model[7]);

        // R3 conversion strobes
        sc = strobe_cnt;
        do_conv(2'b01, 4'h5);
        check(strobe_cnt == sc + 1, "R3 strobe pdown", strobe_cnt, sc + 1);
        check(seen_mode == 2'b01 && seen_rate == 4'h5, "R3 fields pdown", {seen_mode, seen_rate}, 6'h15);
        do_conv(2'b10, 4'hC);
        check(seen_mode == 2'b10 && seen_rate == 4'hC, "R3 fields cal", {seen_mode, seen_rate}, 6'h2C);
        do_conv(2'b11, 4'hF);
        check(seen_mode == 2'b11 && seen_rate == 4'hF, "R3 fields seq", {seen_mode, seen_rate}, 6'h3F);
        check(strobe_cnt == sc + 3 && wide_cnt == 0, "R3 one-cycle pulse", wide_cnt, 0);

        // R4 unused mode
        sc = strobe_cnt;
        do_conv(2'b00, 4'h9);
        check(strobe_cnt == sc, "R4 no strobe", strobe_cnt, sc);

        // R2 leading bit clear: byte 0x4E then 16 data bits for reg 7
        sc = strobe_cnt;
        frame(24, {40'd0, 8'h4E, 16'h1234}, rx);
        frame(8, {56'd0, 8'h21}, rx);
        do_read(7, 16, 24'h0, v);
        check(v == model[7], "R2 frame discarded", v, model[7]);
        check(strobe_cnt == sc, "R2 no strobe", strobe_cnt, sc);

        // R6 short and long writes leave registers unchanged
        do_write(7, 24'h00BEEF, 15, rx);
        do_read(7, 16, 24'h0, v);
        check(v == model[7], "R6 short write", v, model[7]);
        do_write(2, 24'h00015A, 9, rx);
        do_read(2, 8, 24'h0, v);
        check(v == model[2], "R6 long write", v, model[2]);
        do_write(11, 24'h00FFFF, 16, rx);
        do_read(11, 16, 24'h0, v);
        check(v == 24'h00FFFF, "R6 exact write", v, 24'hFFFF);

        // R8 unimplemented address
        do_write(20, 24'h0000AA, 8, rx);
        do_read(20, 8, 24'h0, v);
        check(v == 24'h0, "R8 unimplemented", v, 0);

        // R10 frame cut mid-command then a clean read
        frame(4, {60'd0, 4'b1110}, rx);
        do_read(14, 24, 24'h0, v);
        check(v == model[14], "R10 restart", v, model[14]);
        check(miso == 1'b0, "R9 miso idle", 64'(miso), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule